// File: doc/BRIEF.md
# Multicore Reset Controller Register Block

This block is the register front end of a reset controller that serves a cluster of four processor cores. Software reaches it over a simple 32-bit register bus that takes whole, word-aligned accesses inside a 4 KiB window. Sixteen registers sit at the bottom of that window: one control register, two boot-mode words, a reset status word, an interrupt status word, an interrupt mask word and ten general-purpose words. The general-purpose words hold the entry address and the argument for each secondary core.

A write to the control register does more than store the value. The block compares the old contents with the new word and acts only on the bits that differ. A change on a core enable bit starts or stops that core. The start request carries that core's entry address and argument, taken from its pair of general-purpose registers. A per-core reset bit that changes sends a reset request to its core. Two peripheral soft-reset bits are acknowledged by clearing them. All of these requests leave the block as single-cycle pulses on dedicated outputs.

Top module: `core_reset_regs`

## Requirements
- R1: The register index is address bits [11:2]. The indices are 0 control, 1 boot mode A, 2 reset status, 3 interrupt status, 4 interrupt mask, 5 boot mode B and 6..15 general-purpose words 1..10. `rdata` shows the indexed register in the same cycle.
- R2: After reset, control reads 0x00000521, reset status reads 0x00000001 and interrupt mask reads 0x0000001F. Every other register reads 0.
- R3: A read at an index of 16 or more returns 0. A write there changes no register.
- R4: A write to any index from 1 to 15 stores the written word unchanged.
- R5: Control bits 22, 23 and 24 enable cores 1, 2 and 3. When a write changes one of these bits from 0 to 1, `core_start[c]` pulses. During the pulse, `start_entry[32c+:32]` and `start_arg[32c+:32]` hold the values of general-purpose words 3/4 (core 1), 5/6 (core 2) or 7/8 (core 3).
- R6: When a write changes an enable bit from 1 to 0, `core_stop[c]` pulses. Start and stop never pulse together for the same core.
- R7: Control bits 13..16 are the reset bits of cores 0..3. Writing 1 to one of them pulses `core_reset[c]`. These bits always read back as 0.
- R8: In a write that changes core c's enable bit, core c's reset bit is dropped: there is no `core_reset[c]` pulse and the bit reads 0.
- R9: Control bits 3 and 12 read back as 0 after any write and cause no pulse. All other control bits are plain storage.
- R10: Every pulse is high for exactly the one cycle after the clock edge that took the write. Bit 0 of `core_start` and of `core_stop` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W | Byte address within the window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| core_start | output | 4 | Per-core start pulse |
| core_stop | output | 4 | Per-core stop pulse |
| core_reset | output | 4 | Per-core reset pulse |
| start_entry | output | 128 | Entry address per core, 32 bits per core |
| start_arg | output | 128 | Entry argument per core, 32 bits per core |

## Verification
The bench uses the defaults ADDR_W = 12 and NGPR = 10, so the decoder covers 1024 word slots and only 16 of them are real registers. This lets the bench probe index 16, which would fold back onto the control register if the decode kept too few bits, and the last word of the window. It also writes enable and reset bits for several cores in a single word, so the XOR mask, the suppression of resets and the choice of general-purpose pair are all exercised together.

// File: rtl/core_reset_regs.sv
module core_reset_regs #(
  parameter int ADDR_W = 12,
  parameter int NGPR   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic [3:0]        core_start,
  output logic [3:0]        core_stop,
  output logic [3:0]        core_reset,
  output logic [127:0]      start_entry,
  output logic [127:0]      start_arg
);
  localparam int NREG    = 6 + NGPR;
  localparam int IDX_W   = ADDR_W - 2;
  localparam int RW      = $clog2(NREG);
  localparam int RST_LSB = 13;
  localparam int EN_LSB  = 22;
  localparam int GPR0    = 6;

  logic [31:0] regs [NREG];
  logic [IDX_W-1:0] idx;
  logic [RW-1:0] ri;
  logic in_rng, ctrl_wr;
  logic [31:0] chg, ctrl_nxt;
  logic [3:0] st_n, sp_n, rs_n;

  assign idx     = addr[ADDR_W-1:2];
  assign ri      = idx[RW-1:0];
  assign in_rng  = idx < IDX_W'(NREG);
  assign ctrl_wr = wr_en && idx == '0;
  assign rdata   = in_rng ? regs[ri] : 32'h0;

  always_comb begin
    chg      = regs[0] ^ wdata;
    ctrl_nxt = wdata;
    st_n = '0; sp_n = '0; rs_n = '0;
    for (int c = 1; c < 4; c++) begin
      if (chg[EN_LSB+c-1]) begin
        st_n[c] = wdata[EN_LSB+c-1];
        sp_n[c] = !wdata[EN_LSB+c-1];
        ctrl_nxt[RST_LSB+c] = 1'b0;
        chg[RST_LSB+c] = 1'b0;
      end
    end
    for (int c = 0; c < 4; c++) begin
      if (chg[RST_LSB+c]) begin
        rs_n[c] = 1'b1;
        ctrl_nxt[RST_LSB+c] = 1'b0;
      end
    end
    if (chg[3])  ctrl_nxt[3]  = 1'b0;
    if (chg[12]) ctrl_nxt[12] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= 32'h0;
      regs[0] <= 32'h0000_0521;
      regs[2] <= 32'h0000_0001;
      regs[4] <= 32'h0000_001F;
      core_start  <= '0;
      core_stop   <= '0;
      core_reset  <= '0;
      start_entry <= '0;
      start_arg   <= '0;
    end else begin
      core_start <= ctrl_wr ? st_n : 4'h0;
      core_stop  <= ctrl_wr ? sp_n : 4'h0;
      core_reset <= ctrl_wr ? rs_n : 4'h0;
      for (int c = 1; c < 4; c++) begin
        if (ctrl_wr && st_n[c]) begin
          start_entry[32*c +: 32] <= regs[GPR0 + 2*c];
          start_arg[32*c +: 32]   <= regs[GPR0 + 2*c + 1];
        end
      end
      if (wr_en && in_rng) regs[ri] <= (ri == '0) ? ctrl_nxt : wdata;
    end
  end

  // R10
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_start != 4'h0 |=> (core_start & $past(core_start)) == 4'h0);
  // R6
  start_stop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_start & core_stop) == 4'h0);
  // R8
  enable_no_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((core_start | core_stop) & core_reset) == 4'h0);
  // R7
  rst_bits_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    regs[0][RST_LSB+3:RST_LSB] == 4'h0);
  // R9
  periph_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !regs[0][3] && !regs[0][12]);
  // R5
  pulse_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_start | core_stop | core_reset) != 4'h0 |-> $past(ctrl_wr));
endmodule

// File: tb/sim_core_reset_regs.sv
`timescale 1ns/1ps
module sim_core_reset_regs;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0] core_start, core_stop, core_reset;
  logic [127:0] start_entry, start_arg;
  int checks = 0, fails = 0;

  core_reset_regs u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .core_start(core_start), .core_stop(core_stop), .core_reset(core_reset),
    .start_entry(start_entry), .start_arg(start_arg));

  always #2.5 clk = ~clk;

  localparam int NV = 8;
  localparam logic [75:0] VEC [NV] = '{
    {12'h004, 32'hA5A5_0001, 32'hA5A5_0001},
    {12'h008, 32'h0000_00F0, 32'h0000_00F0},
    {12'h00C, 32'h1234_5678, 32'h1234_5678},
    {12'h010, 32'h0000_0000, 32'h0000_0000},
    {12'h014, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
    {12'h03C, 32'hCAFE_0010, 32'hCAFE_0010},
    {12'h040, 32'h1111_1111, 32'h0000_0000},
    {12'hFFC, 32'h2222_2222, 32'h0000_0000}
  };

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic pulses(input string tag, input logic [3:0] s, input logic [3:0] p, input logic [3:0] r);
    chk({tag, " start"}, {124'h0, core_start}, {124'h0, s});
    chk({tag, " stop"},  {124'h0, core_stop},  {124'h0, p});
    chk({tag, " reset"}, {124'h0, core_reset}, {124'h0, r});
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R2 reset values, R1 index map
    rd(12'h000, d); chk("R2 control", d, 32'h521);
    rd(12'h008, d); chk("R2 status", d, 32'h1);
    rd(12'h010, d); chk("R2 mask", d, 32'h1F);
    rd(12'h004, d); chk("R2 boot A", d, 0);
    rd(12'h018, d); chk("R2 gpr1", d, 0);
    pulses("R2 idle", 0, 0, 0);

    // R1 R3 R4 vector walk
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][75:64], VEC[i][63:32]);
      pulses("R4 no pulse", 0, 0, 0);
      rd(VEC[i][75:64], d); chk("R1 R3 R4 readback", d, VEC[i][31:0]);
    end
    // R3 out-of-range writes left control and boot A alone
    rd(12'h000, d); chk("R3 control untouched", d, 32'h521);
    rd(12'h004, d); chk("R3 boot A untouched", d, 32'hA5A5_0001);

    wr(12'h020, 32'h1000_0100); wr(12'h024, 32'h11);
    wr(12'h028, 32'h2000_0200); wr(12'h02C, 32'h22);
    wr(12'h030, 32'h3000_0300); wr(12'h034, 32'h33);

    // R5 core1 start, R7 core0 reset, R8 core1 reset dropped
    wr(12'h000, 32'h0040_0521 | (1 << 14) | (1 << 13));
    pulses("R5 R8 core1 up", 4'b0010, 0, 4'b0001);
    chk("R5 entry1", start_entry[63:32], 32'h1000_0100);
    chk("R5 arg1", start_arg[63:32], 32'h11);
    rd(12'h000, d); chk("R7 R8 ctrl", d, 32'h0040_0521);
    @(negedge clk); pulses("R10 one cycle", 0, 0, 0);

    // R5 cores 2 and 3 together
    wr(12'h000, 32'h01C0_0521);
    pulses("R5 core2/3 up", 4'b1100, 0, 0);
    chk("R5 entry2", start_entry[95:64], 32'h2000_0200);
    chk("R5 arg2", start_arg[95:64], 32'h22);
    chk("R5 entry3", start_entry[127:96], 32'h3000_0300);
    chk("R5 arg3", start_arg[127:96], 32'h33);

    // R6 core1 stop, R7 core2/3 resets
    wr(12'h000, 32'h0180_0521 | (1 << 15) | (1 << 16));
    pulses("R6 R7 stop and resets", 4'b0000, 4'b0010, 4'b1100);
    rd(12'h000, d); chk("R7 ctrl", d, 32'h0180_0521);

    // R9 peripheral bits and plain storage
    wr(12'h000, 32'h0180_0523 | (1 << 3) | (1 << 12));
    pulses("R9 no pulse", 0, 0, 0);
    rd(12'h000, d); chk("R9 ctrl", d, 32'h0180_0523);

    // R7 core1 reset alone
    wr(12'h000, 32'h0180_0523 | (1 << 14));
    pulses("R7 core1 reset", 0, 0, 4'b0010);
    rd(12'h000, d); chk("R7 reads zero", d, 32'h0180_0523);

    // R8 core3 stop drops its reset
    wr(12'h000, 32'h0080_0523 | (1 << 16));
    pulses("R8 core3 stop", 0, 4'b1000, 0);
    rd(12'h000, d); chk("R8 ctrl", d, 32'h0080_0523);

    // R10 rewriting same value gives no pulse
    wr(12'h000, 32'h0080_0523);
    pulses("R10 same value", 0, 0, 0);

    finish_run();
  end
endmodule